// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block takes a fast reference clock and produces a slower clock for an output pin. The ratio comes from a 5-bit field. A value of 0 or 1 sends the reference clock through unchanged. Any larger value N gives an output period of N reference cycles.

For odd ratios there are two ways to shape the waveform. In the plain mode a single flop drives the output, and the low half is one reference cycle shorter than the high half. In the balanced mode a rising-edge flop and a falling-edge flop are combined, and both halves are N/2 reference cycles long. An inversion control flips the output polarity, including the level the pin holds while idle.

Changes never cut a period short. A new ratio, and a request to disable, both wait until the current period ends. A restart strobe aborts the current period at once, so that a new ratio applies without waiting. An idle flag lets software see when the output has stopped.

Top module: `clk_out_divider`

## Requirements
- R1: A ratio field of 0 or 1 makes the output follow the reference clock: 1 reference cycle per period, high for half of it.
- R2: For a ratio N from 2 to 31, the output period is exactly N reference cycles.
- R3: With balancing off and inversion off, the output is low for floor(N/2) reference cycles and then high for ceil(N/2) reference cycles. For odd N the low half is therefore one cycle shorter.
- R4: With balancing on and N odd, the output is high for N/2 reference cycles, counted in half-cycles (N half-cycles out of 2N).
- R5: With inversion on, the output is the complement of the non-inverted waveform. The idle level is then 1 instead of 0.
- R6: When the enable drops, the period in progress runs to its end. After that the output holds its idle level and the idle flag reads 1.
- R7: A ratio written while the output runs applies only from the next period boundary.
- R8: A restart strobe ends the current period at once. On the clock edge that samples the strobe, the idle flag goes to 1. If enable is still high, the output restarts on the next edge with the ratio present at that time.
- R9: The balancing and inversion controls are captured only while the output is idle. Changing them while it runs has no effect on the waveform.
- R10: After reset the output is idle: the idle flag is 1 and the output is 0 when inversion is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| div_sel | input | 5 | Division ratio; 0 and 1 mean pass-through |
| sym_req | input | 1 | Balanced duty cycle for odd ratios |
| inv_req | input | 1 | Invert the output polarity |
| out_en | input | 1 | Run the divided clock |
| restart | input | 1 | Strobe that aborts the current period |
| clk_out | output | 1 | Divided clock |
| idle | output | 1 | 1 while the output is stopped |

## Verification
A wrong count or shadow ratio appears at the pin as a wrong rise-to-rise interval within the next one or two periods. A wrong phase threshold changes the high/low split in the very next period. The bench measures both intervals in half-cycle steps, so an error in the falling-edge flop shows as an off-by-one half-cycle. A wrong run/stop state shows as a truncated final high phase, or as an idle flag that lags the restart strobe by a cycle. Both are checked on the first cycle where they can differ.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  parameter int DIV_W = 5;
  typedef logic [DIV_W-1:0] div_t;

  // length of the low phase for a divide ratio
  function automatic div_t low_len(input div_t n);
    return n >> 1;
  endfunction

  function automatic logic is_bypass(input div_t n);
    return n < div_t'(2);
  endfunction
endpackage

// File: rtl/cdiv_core.sv
module cdiv_core
  import cdiv_pkg::*;
(
  input  logic clk_ref,
  input  logic rst,
  input  div_t div_sel,
  input  logic sym_req,
  input  logic inv_req,
  input  logic out_en,
  input  logic restart,
  output logic run_o,
  output logic ph_o,
  output logic bypass_o,
  output logic bal_o,
  output logic inv_o
);
  logic run_q, ph_q, sym_q, inv_q;
  div_t cnt_q, n_q, lim, cnt_inc;
  logic at_end;

  always_comb begin
    lim     = is_bypass(n_q) ? '0 : n_q - div_t'(1);
    at_end  = (cnt_q == lim);
    cnt_inc = cnt_q + div_t'(1);
  end

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      n_q   <= '0;
      ph_q  <= 1'b0;
      sym_q <= 1'b0;
      inv_q <= 1'b0;
    end else if (restart) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      ph_q  <= 1'b0;
      n_q   <= div_sel;
    end else if (!run_q) begin
      sym_q <= sym_req;
      inv_q <= inv_req;
      n_q   <= div_sel;
      cnt_q <= '0;
      ph_q  <= 1'b0;
      if (out_en) run_q <= 1'b1;
    end else if (at_end) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
      if (out_en) n_q <= div_sel;
      else        run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_inc;
      ph_q  <= !is_bypass(n_q) && (cnt_inc >= low_len(n_q));
    end
  end

  assign run_o    = run_q;
  assign ph_o     = ph_q;
  assign bypass_o = run_q && is_bypass(n_q);
  assign bal_o    = sym_q && n_q[0] && !is_bypass(n_q);
  assign inv_o    = inv_q;

  AST_CNT_RANGE: assert property (@(posedge clk_ref) disable iff (rst)
    run_q |-> cnt_q <= lim); // R2
  AST_STOP_AT_END: assert property (@(posedge clk_ref) disable iff (rst)
    $fell(run_q) |-> ($past(restart) || $past(at_end))); // R6
  AST_RATIO_HELD: assert property (@(posedge clk_ref) disable iff (rst)
    (run_q && !at_end && !restart) |=> $stable(n_q)); // R7
  AST_CLR_IDLE: assert property (@(posedge clk_ref) disable iff (rst)
    restart |=> !run_q); // R8
  AST_CFG_HELD: assert property (@(posedge clk_ref) disable iff (rst)
    (run_q && $past(run_q)) |-> ($stable(sym_q) && $stable(inv_q))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_ref) disable iff (rst)
    !run_q |-> (cnt_q == '0 && !ph_q)); // R10
endmodule

// File: rtl/cdiv_shaper.sv
module cdiv_shaper (
  input  logic clk_ref,
  input  logic rst,
  input  logic ph,
  input  logic bypass,
  input  logic bal,
  input  logic inv,
  output logic clk_out
);
  logic ph_neg, gate_lat, div_wave, raw;

  // half-cycle delayed copy of the phase flop
  always_ff @(negedge clk_ref) begin
    if (rst) ph_neg <= 1'b0;
    else     ph_neg <= ph;
  end

  // gate latch is open only while the reference clock is low
  always_latch begin
    if (!clk_ref) gate_lat = bypass;
  end

  always_comb begin
    div_wave = bal ? (ph & ph_neg) : ph;
    raw      = (clk_ref & gate_lat) | div_wave;
    clk_out  = raw ^ inv;
  end

  AST_BYPASS_NO_PHASE: assert property (@(posedge clk_ref) disable iff (rst)
    bypass |-> !ph); // R1
endmodule

// File: rtl/clk_out_divider.sv
module clk_out_divider
  import cdiv_pkg::*;
(
  input  logic             clk_ref,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             sym_req,
  input  logic             inv_req,
  input  logic             out_en,
  input  logic             restart,
  output logic             clk_out,
  output logic             idle
);
  logic run, ph, bypass, bal, inv;

  cdiv_core u_core (
    .clk_ref  (clk_ref),
    .rst      (rst),
    .div_sel  (div_sel),
    .sym_req  (sym_req),
    .inv_req  (inv_req),
    .out_en   (out_en),
    .restart  (restart),
    .run_o    (run),
    .ph_o     (ph),
    .bypass_o (bypass),
    .bal_o    (bal),
    .inv_o    (inv)
  );

  cdiv_shaper u_shape (
    .clk_ref (clk_ref),
    .rst     (rst),
    .ph      (ph),
    .bypass  (bypass),
    .bal     (bal),
    .inv     (inv),
    .clk_out (clk_out)
  );

  assign idle = !run;
endmodule

// File: tb/tb_clk_out_divider.sv
module tb_clk_out_divider;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] div_sel = '0;
  logic sym_req = 1'b0, inv_req = 1'b0, out_en = 1'b0, restart = 1'b0;
  logic clk_out, idle;
  int total = 0, bad = 0;
  logic hist[$];

  always #5 clk = ~clk;

  clk_out_divider dut (
    .clk_ref(clk), .rst(rst), .div_sel(div_sel), .sym_req(sym_req),
    .inv_req(inv_req), .out_en(out_en), .restart(restart),
    .clk_out(clk_out), .idle(idle)
  );

  // one sample in the high half, one in the low half of each cycle
  always @(posedge clk) begin
    #2 hist.push_back(clk_out);
    #5 hist.push_back(clk_out);
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_per(input int n);
    return (n < 2) ? 2 : 2 * n;
  endfunction

  function automatic int exp_hi(input int n, input bit s, input bit v);
    int b;
    if (n < 2) return 1;
    b = (s && n[0]) ? n : 2 * ((n + 1) / 2);
    return v ? 2 * n - b : b;
  endfunction

  // last complete rise-to-rise interval, in half-cycles
  function automatic void meas(output int per, output int hi);
    int r2 = -1, r1 = -1;
    per = -1; hi = -1;
    for (int i = 1; i < hist.size(); i++)
      if (!hist[i-1] && hist[i]) begin r1 = r2; r2 = i; end
    if (r1 < 0) return;
    per = r2 - r1; hi = 0;
    for (int i = r1; i < r2; i++) hi += hist[i];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    @(posedge clk); #1 out_en = 1'b0;
    for (int i = 0; i < 100 && !idle; i++) tick(1);
    tick(2);
  endtask

  task automatic run_cfg(input int n, input bit s, input bit v, input string req);
    int per, hi;
    wait_idle();
    div_sel = 5'(n); sym_req = s; inv_req = v; out_en = 1'b1;
    tick(n + 3);
    hist.delete();
    tick(2 * n + 8);
    meas(per, hi);
    chk({req, " period"}, per, exp_per(n));
    chk({req, " high"}, hi, exp_hi(n, s, v));
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int per, hi, last_run, idx;
    int rises[$];
    void'($urandom(32'd4711));
    tick(4);
    @(posedge clk); #1 rst = 1'b0;
    @(posedge clk); #2;
    chk("R10 idle after reset", idle, 1);
    chk("R10 output after reset", clk_out, 0);

    run_cfg(0, 0, 0, "R1 ratio0");
    run_cfg(1, 1, 0, "R1 ratio1");
    run_cfg(4, 0, 0, "R2 even4");
    run_cfg(5, 0, 0, "R3 odd5 plain");
    run_cfg(9, 0, 0, "R3 odd9 plain");
    run_cfg(5, 1, 0, "R4 odd5 balanced");
    run_cfg(2, 1, 0, "R4 ratio2 balanced");
    run_cfg(5, 0, 1, "R5 odd5 inverted");
    run_cfg(7, 1, 1, "R5 odd7 bal inverted");

    // R6: disable at varying points, last high phase must be whole
    for (int t = 0; t < 3; t++) begin
      run_cfg(7, 0, 0, "R6 setup");
      hist.delete();
      tick(14 + int'($urandom_range(0, 6)));
      out_en = 1'b0;
      tick(24);
      last_run = 0; idx = hist.size() - 1;
      while (idx >= 0 && !hist[idx]) idx--;
      while (idx >= 0 && hist[idx]) begin last_run++; idx--; end
      chk("R6 final high phase", last_run, 8);
      chk("R6 output idle", clk_out, 0);
      chk("R6 idle flag", idle, 1);
    end

    // R7: ratio written mid-period takes effect at the boundary
    run_cfg(6, 0, 0, "R7 setup");
    hist.delete();
    @(posedge clk_out);
    tick(1);
    div_sel = 5'd3;
    tick(20);
    rises.delete();
    for (int i = 1; i < hist.size(); i++)
      if (!hist[i-1] && hist[i]) rises.push_back(i);
    chk("R7 rise count", int'(rises.size() >= 3), 1);
    if (rises.size() >= 3) begin
      chk("R7 bridging interval", rises[1] - rises[0], 8);
      chk("R7 new interval", rises[rises.size()-1] - rises[rises.size()-2], 6);
    end

    // R8: restart aborts a long period
    run_cfg(20, 0, 0, "R8 setup");
    tick(5);
    div_sel = 5'd2; restart = 1'b1;
    tick(1);
    restart = 1'b0;
    chk("R8 idle after restart", idle, 1);
    hist.delete();
    tick(10);
    meas(per, hi);
    chk("R8 new period", per, 4);
    chk("R8 new high", hi, 2);

    // R9: balancing and inversion ignored while running
    run_cfg(5, 0, 0, "R9 setup");
    sym_req = 1'b1; inv_req = 1'b1;
    hist.delete();
    tick(20);
    meas(per, hi);
    chk("R9 period unchanged", per, 10);
    chk("R9 high unchanged", hi, 6);
    wait_idle();
    #1;
    chk("R5 inverted idle level", clk_out, 1);

    // random configurations
    for (int k = 0; k < 12; k++) begin
      int n;
      bit s, v;
      n = int'($urandom_range(0, 31));
      s = 1'($urandom_range(0, 1));
      v = 1'($urandom_range(0, 1));
      run_cfg(n, s, v, (n < 2) ? "R1 random" : (s ? "R4 random" : "R3 random"));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule